// File: doc/BRIEF.md
# Fine-Adjusted PWM DAC Timer

This block turns a 14-bit digital value into a pulse train. After an external RC filter, the average level of that pulse train follows the value. A free-running 14-bit counter steps once per clock, and one clock is one resolution step T. The counter is split into a position within a short base cycle and an index that says which base cycle is running.

The upper bits of the value set the coarse high time of every base cycle. The lower bits set how many base cycles in one 16384-step conversion period get one extra step of high time. The base-cycle index is bit-reversed before it is compared, so those extra steps are spread evenly over the period. A per-channel carrier bit selects a base cycle of 64 or 256 steps. A value below the legal floor for the chosen carrier leaves the output constantly low.

Two channels share the counter. A small word-addressed register port gives access to them. Two word addresses each carry two registers. A view-select flag decides whether the two addresses show the two data registers, or the control register and the counter.

Top module: `pwmdac`

## Requirements
- R1: After reset, each data register holds value 0x3FFF with carrier bit 1, the view-select flag is 1, and both channel enables are 0. Reading address 0 in the control view therefore returns 0xFFF9. Reading either data register in the data view returns 0xFFFE.
- R2: Every write loads the view-select flag from `wrData[0]`. The flag in force before the write picks the target. With the flag at 0, address 0 is channel A data and address 1 is channel B data, both laid out as value in bits 15..2, carrier in bit 1, flag in bit 0. With the flag at 1, address 0 is the control register and address 1 is the counter. The control register has the channel A enable in bit 1, the channel B enable in bit 2, the flag in bit 0, and reads 1 in bits 15..3. The counter is read and loaded in bits 15..2, reads 1 in bit 1, and reads the flag in bit 0. Data registers are unchanged while the flag is 1.
- R3: The counter increases by one every clock and wraps from 0x3FFF to 0. A counter write replaces the count instead.
- R4: With carrier bit 0 and a value from 0x0100 to 0x3FFF, the output is high for exactly that many clocks in every 16384-clock window.
- R5: With carrier bit 1 and a value from 0x0040 to 0x3FFF, the output is high for exactly that many clocks in every 16384-clock window.
- R6: A value below the floor for its carrier keeps the output low, with no transitions at all.
- R7: High time starts only at the first step of a base cycle. As long as the coarse field is below the last base position, the output rises exactly once per base cycle: 256 times per period with carrier 0, 64 times with carrier 1.
- R8: When value bits 1..0 are 0 (12-bit use), every 4096-clock window holds exactly one quarter of the value in high clocks.
- R9: The value, carrier and enable registers take effect only when the counter wraps. A write in the middle of a period leaves the rest of that period on the old settings.
- R10: A disabled channel drives its output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one resolution step |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Single-cycle register write strobe |
| addr | input | 1 | Word address within the register port |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `addr` |
| pwmOut | output | 2 | Registered PWM outputs, bit 0 channel A, bit 1 channel B |

## Verification
The check that a rise falls on a base-cycle start assumes the counter runs undisturbed. It therefore ignores the two cycles after any counter load, and the stimulus only loads the counter with its wrap value, so periods stay aligned. The assertions also assume that `wrEn` is a clean single-cycle strobe with `addr` and `wrData` steady around the sampling edge. The bench drives all of these at the falling edge. Reset is held for several clocks before the first write, so the settings registers start from known values.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
  localparam int CNT_W  = 14;
  localparam int NCH    = 2;
  localparam int REG_W  = CNT_W + 2;
  localparam int BASE_S = 6;
  localparam int BASE_L = 8;

  typedef struct packed {
    logic             cntLoad;
    logic [CNT_W-1:0] cntVal;
  } strb_t;
endpackage

// File: rtl/pwmdac_chan.sv
module pwmdac_chan
  import pwmdac_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int BS = BASE_S,
  parameter int BL = BASE_L
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          periodEnd,
  input  logic          cntLoad,
  input  logic [CW-1:0] dataIn,
  input  logic          cfsIn,
  input  logic          enIn,
  output logic          pwmOut
);
  localparam int FS = CW - BS;
  localparam int FL = CW - BL;
  localparam logic [CW-1:0] MIN_S = CW'(1) << FS;
  localparam logic [CW-1:0] MIN_L = CW'(1) << FL;

  logic [CW-1:0] dataQ;
  logic          cfsQ;
  logic          enQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataQ <= '1;
      cfsQ  <= 1'b1;
      enQ   <= 1'b0;
    end else if (periodEnd) begin
      dataQ <= dataIn;
      cfsQ  <= cfsIn;
      enQ   <= enIn;
    end
  end

  logic [FS-1:0] revS;
  logic [FL-1:0] revL;
  for (genvar i = 0; i < FS; i++) begin : g_revS
    assign revS[i] = cnt[CW-1-i];
  end
  for (genvar i = 0; i < FL; i++) begin : g_revL
    assign revL[i] = cnt[CW-1-i];
  end

  logic [BS-1:0] posS;
  logic [BL-1:0] posL;
  logic          hitS, hitL, legal, posStart, nxt;

  always_comb begin
    posS = cnt[BS-1:0];
    posL = cnt[BL-1:0];
    hitS = (posS < dataQ[CW-1:FS]) ||
           ((posS == dataQ[CW-1:FS]) && (revS < dataQ[FS-1:0]));
    hitL = (posL < dataQ[CW-1:FL]) ||
           ((posL == dataQ[CW-1:FL]) && (revL < dataQ[FL-1:0]));
    legal    = cfsQ ? (dataQ >= MIN_L) : (dataQ >= MIN_S);
    posStart = cfsQ ? (posL == '0) : (posS == '0);
    nxt      = enQ && legal && (cfsQ ? hitL : hitS);
  end

  always_ff @(posedge clk) begin
    if (rst) pwmOut <= 1'b0;
    else     pwmOut <= nxt;
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !periodEnd |=> ($stable(dataQ) && $stable(cfsQ) && $stable(enQ))); // R9
  AST_ILLEGAL_LOW: assert property (@(posedge clk) disable iff (rst)
    !legal |=> !pwmOut); // R6
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !enQ |=> !pwmOut); // R10
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwmOut) && !$past(cntLoad, 2)) |-> $past(posStart)); // R7
endmodule

// File: rtl/pwmdac_ctrl.sv
module pwmdac_ctrl
  import pwmdac_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wrEn,
  input  logic                      addr,
  input  logic [REG_W-1:0]          wrData,
  input  logic [CNT_W-1:0]          cnt,
  output logic [REG_W-1:0]          rdData,
  output strb_t                     strb,
  output logic [NCH-1:0][CNT_W-1:0] chData,
  output logic [NCH-1:0]            chCfs,
  output logic [NCH-1:0]            chEn
);
  logic sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= 1'b1;
      chEn   <= '0;
      chData <= '1;
      chCfs  <= '1;
    end else if (wrEn) begin
      sel <= wrData[0];
      if (!sel) begin
        chData[addr] <= wrData[REG_W-1:2];
        chCfs[addr]  <= wrData[1];
      end else if (!addr) begin
        chEn <= wrData[NCH:1];
      end
    end
  end

  always_comb begin
    strb.cntLoad = wrEn && sel && addr;
    strb.cntVal  = wrData[REG_W-1:2];
    if (!sel)      rdData = {chData[addr], chCfs[addr], sel};
    else if (addr) rdData = {cnt, 1'b1, sel};
    else           rdData = {{(REG_W-NCH-1){1'b1}}, chEn, sel};
  end

  AST_SEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> (sel == $past(wrData[0]))); // R2
  AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wrEn && sel) |=> ($stable(chData) && $stable(chCfs))); // R2
endmodule

// File: rtl/pwmdac_dp.sv
module pwmdac_dp
  import pwmdac_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  strb_t                     strb,
  input  logic [NCH-1:0][CNT_W-1:0] chData,
  input  logic [NCH-1:0]            chCfs,
  input  logic [NCH-1:0]            chEn,
  output logic [CNT_W-1:0]          cnt,
  output logic [NCH-1:0]            pwmOut
);
  logic periodEnd;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (strb.cntLoad) cnt <= strb.cntVal;
    else                   cnt <= cnt + 1'b1;
  end

  assign periodEnd = &cnt;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwmdac_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .cnt      (cnt),
      .periodEnd(periodEnd),
      .cntLoad  (strb.cntLoad),
      .dataIn   (chData[c]),
      .cfsIn    (chCfs[c]),
      .enIn     (chEn[c]),
      .pwmOut   (pwmOut[c])
    );
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !strb.cntLoad |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R3
endmodule

// File: rtl/pwmdac.sv
module pwmdac
  import pwmdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic             addr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic [NCH-1:0]   pwmOut
);
  strb_t                     strb;
  logic [NCH-1:0][CNT_W-1:0] chData;
  logic [NCH-1:0]            chCfs;
  logic [NCH-1:0]            chEn;
  logic [CNT_W-1:0]          cnt;

  pwmdac_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cnt(cnt), .rdData(rdData), .strb(strb),
    .chData(chData), .chCfs(chCfs), .chEn(chEn)
  );

  pwmdac_dp u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .chData(chData), .chCfs(chCfs), .chEn(chEn),
    .cnt(cnt), .pwmOut(pwmOut)
  );
endmodule

// File: tb/sim_pwmdac.sv
module sim_pwmdac;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  pwmOut;

  pwmdac u0 (.clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr),
             .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut));

  always #5 clk = ~clk;

  // rows: valueA, carrierA, valueB, carrierB, expected high A, expected high B
  localparam logic [15:0] VEC [8][6] = '{
    '{16'h0100, 16'd0, 16'h0040, 16'd1, 16'd256,   16'd64},
    '{16'h3FFF, 16'd0, 16'h3FFF, 16'd1, 16'd16383, 16'd16383},
    '{16'h00FF, 16'd0, 16'h003F, 16'd1, 16'd0,     16'd0},
    '{16'h1235, 16'd0, 16'h2A7C, 16'd1, 16'd4661,  16'd10876},
    '{16'h0040, 16'd0, 16'h00FF, 16'd1, 16'd0,     16'd255},
    '{16'h2000, 16'd0, 16'h1001, 16'd1, 16'd8192,  16'd4097},
    '{16'h0A54, 16'd0, 16'h0000, 16'd1, 16'd2644,  16'd0},
    '{16'h37F8, 16'd1, 16'h0155, 16'd0, 16'd14328, 16'd341}
  };

  int nChk = 0;
  int nFail = 0;
  int hi[2], qhi[2], rises[2], trans[2];

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic a, output logic [15:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic measure(int len);
    logic [1:0] prev;
    prev = pwmOut;
    for (int c = 0; c < 2; c++) begin
      hi[c] = 0; qhi[c] = 0; rises[c] = 0; trans[c] = 0;
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        if (pwmOut[c]) hi[c]++;
        if (pwmOut[c] && k < 4096) qhi[c]++;
        if (pwmOut[c] != prev[c]) trans[c]++;
        if (pwmOut[c] && !prev[c]) rises[c]++;
      end
      prev = pwmOut;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [15:0] r, r2;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R10 / R1: outputs idle low while disabled after reset
    measure(100);
    check("R10 channel A high count while disabled", hi[0], 0);
    check("R10 channel B high count while disabled", hi[1], 0);

    rd(1'b0, r);
    check("R1 control register after reset", r, 16'hFFF9);
    rd(1'b1, r);
    check("R2 counter view low bits", r[1:0], 2'b11);
    repeat (5) @(negedge clk);
    rd(1'b1, r2);
    check("R3 counter advance over 5 clocks", 14'(r2[15:2] - r[15:2]), 5);

    wr(1'b0, 16'h0007);
    rd(1'b0, r);
    check("R2 control readback after enable", r, 16'hFFFF);
    wr(1'b1, 16'h0000);
    rd(1'b0, r);
    check("R1 data register A after reset", r, 16'hFFFE);
    rd(1'b1, r);
    check("R1 data register B after reset", r, 16'hFFFE);

    for (int v = 0; v < 8; v++) begin
      wr(1'b0, {VEC[v][0][13:0], VEC[v][1][0], 1'b0});
      wr(1'b1, {VEC[v][2][13:0], VEC[v][3][0], 1'b1});
      wr(1'b1, 16'hFFFC);
      rd(1'b0, r);
      check("R2 data view readback A", r, {VEC[v][0][13:0], VEC[v][1][0], 1'b0});
      repeat (3) @(negedge clk);
      measure(16384);
      for (int c = 0; c < 2; c++) begin
        logic [15:0] d, e;
        logic        cf;
        int          coarse;
        d  = VEC[v][2*c];
        cf = VEC[v][2*c+1][0];
        e  = VEC[v][4+c];
        if (e == 0) begin
          check("R6 high count below floor", hi[c], 0);
          check("R6 transitions below floor", trans[c], 0);
        end else begin
          check(cf ? "R5 high count, 256-step base" : "R4 high count, 64-step base",
                hi[c], e);
          coarse = cf ? int'(d >> 6) : int'(d >> 8);
          if (coarse < (cf ? 255 : 63))
            check("R7 rises per period", rises[c], cf ? 64 : 256);
          if (d[1:0] == 2'b00)
            check("R8 quarter-window high count", qhi[c], int'(e) / 4);
        end
      end
    end

    // R9: mid-period write waits for the wrap
    wr(1'b0, 16'hFFFC);
    wr(1'b1, {14'h0040, 1'b1, 1'b1});
    wr(1'b1, 16'hFFFC);
    repeat (5) @(negedge clk);
    wr(1'b0, {14'h0100, 2'b00});
    repeat (2) @(negedge clk);
    measure(1000);
    check("R9 old value kept for rest of period", hi[0], 1000);
    repeat (16384) @(negedge clk);
    measure(64);
    check("R9 new value after wrap", hi[0], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule